// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block is a purely combinational binary adder. It takes two unsigned operands and a carry-in, and it returns their sum together with the carry-out. It also returns a word-wide generate flag and a word-wide propagate flag. A wider adder can use these two flags to treat this block as one group in a further lookahead level.

Carries are computed by one reusable lookahead cell, used at two levels. Each first-level cell covers a slice of the word. It reduces the per-bit generate and propagate terms of its slice to a pair of group terms, and it forms the carries inside the slice once that slice's incoming carry is known. A single second-level cell takes the group pairs and the carry-in. It returns the carries that enter each slice, plus the word-wide generate and propagate.

With the default slice width of 4 the word is 16 bits wide. The path from input to output is then eight gate levels: bit terms, group terms, slice carries, inner carries, and the sum XOR. A parameter selects how the final carry-out is formed:

- `CO_GROUP` takes it from the word-wide group terms and the carry-in.
- `CO_RIPPLE` takes it as one ripple step from bit 15. This costs fewer gates but adds one gate level.

Top module: `cla_two_level_adder`

## Requirements
- R1: `sum` equals (`op_x` + `op_y` + `carry_in`) modulo 2^16 for every input combination, in the same cycle the inputs are applied.
- R2: `carry_out` equals bit 16 of the 17-bit value `op_x` + `op_y` + `carry_in`.
- R3: `grp_gen` is 1 exactly when `op_x` + `op_y`, with no carry-in, exceeds 16'hFFFF; it does not depend on `carry_in`.
- R4: `grp_prop` is 1 exactly when `op_x` XOR `op_y` equals 16'hFFFF, that is, when every bit position would pass a carry through.
- R5: Whenever `grp_prop` is 1, `grp_gen` is 0, `carry_out` equals `carry_in`, and `sum` is 16'hFFFF when `carry_in` is 0 and 16'h0000 when `carry_in` is 1.
- R6: The carry entering each bit position i+1 equals g(i) OR (p(i) AND c(i)), where g is the AND and p is the XOR of the operand bits. This holds at the slice boundaries 4, 8 and 12, where the carry comes from the second level, as well as inside the slices.
- R7: Both settings of the carry-out selector, `CO_GROUP` (the default) and `CO_RIPPLE`, give identical `sum`, `carry_out`, `grp_gen` and `grp_prop` for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | 16 | First operand, unsigned |
| op_y | input | 16 | Second operand, unsigned |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |
| grp_gen | output | 1 | Word-wide generate: the word produces a carry on its own |
| grp_prop | output | 1 | Word-wide propagate: the word passes an incoming carry through |

## Verification
The embedded checks hold at every input settle. They cover four properties:

- The combined carry-out and sum always match the arithmetic total.
- Every bit's incoming carry follows the one-bit carry step from the bit below. This includes the carries handed down at the slice boundaries.
- Group propagate excludes group generate, both inside each cell and for the whole word.
- The two ways of forming the carry-out agree.

Whether `grp_gen` truly ignores the carry-in, and whether a second instance built with the ripple carry-out option matches the default on every output, can only be shown by the bench. The bench uses directed propagate chains, boundary-crossing increments and random operands to do so.

// File: rtl/cla_pkg.sv
// Package: shared types and defaults for the two-level lookahead adder.
// Assumes: nothing; it holds declarations only.
package cla_pkg;

    // How the top-level carry-out is formed.
    typedef enum logic {
        CO_GROUP  = 1'b0,   // from word group generate/propagate and carry-in
        CO_RIPPLE = 1'b1    // one ripple step from the top bit's carry
    } co_mode_e;

    // Default number of bits per lookahead slice (and slices per word).
    localparam int unsigned CLA_SLICE_DEFAULT = 4;

endpackage

// File: rtl/cla_bit_terms.sv
// Module: per-bit generate (AND) and propagate (XOR) terms of two operands.
// Assumes: operands are plain unsigned vectors of equal width.
module cla_bit_terms #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prop_o
);

    // Form generate and propagate for every bit position.
    always_comb begin : bit_terms
        gen_o  = a_i & b_i;
        prop_o = a_i ^ b_i;
    end

endmodule

// File: rtl/cla_lookahead_cell.sv
// Module: N-input lookahead carry generator. From N generate/propagate pairs
// and an incoming carry it forms the N-1 inner carries in fully expanded
// sum-of-products form, plus group generate and group propagate.
// Assumes: N >= 2; carry_o[k-1] is the carry entering position k of the group.
module cla_lookahead_cell #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    input  logic         cin_i,
    output logic [N-2:0] carry_o,
    output logic         grp_g_o,
    output logic         grp_p_o
);

    // Expanded inner carries: c(k) = OR_j g(j)*p(j+1..k-1) + cin*p(0..k-1).
    always_comb begin : inner_carries
        logic acc;
        logic prod;
        for (int k = 1; k < int'(N); k++) begin
            acc = cin_i;
            for (int m = 0; m < k; m++) begin
                acc = acc & prop_i[m];
            end
            for (int j = 0; j < k; j++) begin
                prod = gen_i[j];
                for (int m = j + 1; m < k; m++) begin
                    prod = prod & prop_i[m];
                end
                acc = acc | prod;
            end
            carry_o[k-1] = acc;
        end
    end

    // Group generate: some bit generates and every bit above it propagates.
    always_comb begin : group_generate
        logic acc;
        logic prod;
        acc = 1'b0;
        for (int j = 0; j < int'(N); j++) begin
            prod = gen_i[j];
            for (int m = j + 1; m < int'(N); m++) begin
                prod = prod & prop_i[m];
            end
            acc = acc | prod;
        end
        grp_g_o = acc;
    end

    // Group propagate: every bit passes a carry through.
    always_comb begin : group_propagate
        grp_p_o = &prop_i;
    end

    // R5: a group that propagates end to end cannot also generate.
    always_comb begin : chk_cell_exclusive
        if (grp_p_o) begin
            a_r5_cell_prop_excludes_gen: assert (!grp_g_o)
                else $error("R5: cell group propagate and generate both high");
        end
    end

endmodule

// File: rtl/cla_sum_stage.sv
// Module: final sum XOR of per-bit propagate with the carry entering each bit.
// Assumes: carry_i[i] is the carry into bit i (carry_i[0] is the word carry-in).
module cla_sum_stage #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] prop_i,
    input  logic [W-1:0] carry_i,
    output logic [W-1:0] sum_o
);

    // Sum bit is propagate XOR incoming carry.
    always_comb begin : sum_xor
        sum_o = prop_i ^ carry_i;
    end

endmodule

// File: rtl/cla_two_level_adder.sv
// Module: combinational adder of SLICE*SLICE bits built from two levels of
// lookahead cells. First-level cells reduce each slice and form its inner
// carries; one second-level cell forms the carries into each slice and the
// word group terms. CO_MODE picks how the carry-out is built.
// Assumes: purely combinational, no clock; SLICE >= 2.
module cla_two_level_adder #(
    parameter int unsigned       SLICE   = cla_pkg::CLA_SLICE_DEFAULT,
    parameter cla_pkg::co_mode_e CO_MODE = cla_pkg::CO_GROUP
) (
    input  logic [SLICE*SLICE-1:0] op_x,
    input  logic [SLICE*SLICE-1:0] op_y,
    input  logic                   carry_in,
    output logic [SLICE*SLICE-1:0] sum,
    output logic                   carry_out,
    output logic                   grp_gen,
    output logic                   grp_prop
);

    localparam int unsigned W   = SLICE * SLICE;
    localparam int unsigned NSL = SLICE;
    localparam int unsigned W1  = W + 1;

    logic [W-1:0]   bit_g;
    logic [W-1:0]   bit_p;
    logic [W-1:0]   bit_c;      // carry into each bit
    logic [NSL-1:0] slc_g;
    logic [NSL-1:0] slc_p;
    logic [NSL-1:0] slc_c;      // carry into each slice
    logic [NSL-2:0] lvl2_c;

    cla_bit_terms #(.W(W)) u_terms (
        .a_i    (op_x),
        .b_i    (op_y),
        .gen_o  (bit_g),
        .prop_o (bit_p)
    );

    // Second level: slice group terms to slice carries and word group terms.
    cla_lookahead_cell #(.N(NSL)) u_level2 (
        .gen_i   (slc_g),
        .prop_i  (slc_p),
        .cin_i   (carry_in),
        .carry_o (lvl2_c),
        .grp_g_o (grp_gen),
        .grp_p_o (grp_prop)
    );

    assign slc_c = {lvl2_c, carry_in};

    // First level: one lookahead cell per slice.
    for (genvar q = 0; q < int'(NSL); q++) begin : g_slice
        cla_lookahead_cell #(.N(SLICE)) u_level1 (
            .gen_i   (bit_g[q*SLICE +: SLICE]),
            .prop_i  (bit_p[q*SLICE +: SLICE]),
            .cin_i   (slc_c[q]),
            .carry_o (bit_c[q*SLICE+1 +: SLICE-1]),
            .grp_g_o (slc_g[q]),
            .grp_p_o (slc_p[q])
        );
        assign bit_c[q*SLICE] = slc_c[q];
    end

    cla_sum_stage #(.W(W)) u_sum (
        .prop_i  (bit_p),
        .carry_i (bit_c),
        .sum_o   (sum)
    );

    // Carry-out variant chosen by CO_MODE.
    if (CO_MODE == cla_pkg::CO_RIPPLE) begin : g_co_ripple
        assign carry_out = bit_g[W-1] | (bit_p[W-1] & bit_c[W-1]);
    end else begin : g_co_group
        assign carry_out = grp_gen | (grp_prop & carry_in);
    end

    // R1, R2: sum and carry-out together equal the arithmetic total.
    always_comb begin : chk_total
        a_r1_r2_total: assert ({carry_out, sum} ==
                               ({1'b0, op_x} + {1'b0, op_y} + W1'(carry_in)))
            else $error("R1/R2: adder total mismatch");
    end

    // R6: each carry from either level agrees with the one-bit carry step.
    always_comb begin : chk_carry_step
        for (int i = 0; i < int'(W) - 1; i++) begin
            a_r6_carry_step: assert (bit_c[i+1] ==
                                     (bit_g[i] | (bit_p[i] & bit_c[i])))
                else $error("R6: carry into bit %0d inconsistent", i + 1);
        end
    end

    // R5: full-word propagate passes carry-in straight through.
    always_comb begin : chk_passthrough
        if (grp_prop) begin
            a_r5_word_passthrough: assert (!grp_gen && (carry_out == carry_in))
                else $error("R5: propagate chain did not pass carry-in");
        end
    end

    // R7: both carry-out formulations agree.
    always_comb begin : chk_co_forms
        a_r7_co_forms_agree: assert ((grp_gen | (grp_prop & carry_in)) ==
                                     (bit_g[W-1] | (bit_p[W-1] & bit_c[W-1])))
            else $error("R7: carry-out formulations differ");
    end

endmodule

// File: tb/cla_two_level_adder_tb.sv
// Bench: scoreboard. The driver applies vectors just after a rising edge and
// queues the expected result; the monitor pops and compares at the falling edge.
module cla_two_level_adder_tb;

    localparam int unsigned W = 16;

    typedef struct {
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic         c;
        logic [W-1:0] exp_sum;
        logic         exp_co;
        logic         exp_g;
        logic         exp_p;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_x = '0;
    logic [W-1:0] op_y = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] sum, sum_alt;
    logic         carry_out, co_alt, grp_gen, g_alt, grp_prop, p_alt;
    int           checks = 0;
    int           errors = 0;
    int           cycles = 0;
    bit           done = 1'b0;
    item_t        sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    cla_two_level_adder u_dut (
        .op_x(op_x), .op_y(op_y), .carry_in(carry_in),
        .sum(sum), .carry_out(carry_out), .grp_gen(grp_gen), .grp_prop(grp_prop)
    );

    cla_two_level_adder #(.CO_MODE(cla_pkg::CO_RIPPLE)) u_alt (
        .op_x(op_x), .op_y(op_y), .carry_in(carry_in),
        .sum(sum_alt), .carry_out(co_alt), .grp_gen(g_alt), .grp_prop(p_alt)
    );

    // Compare one observed value against its expectation.
    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp, input item_t it);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s x=%h y=%h c=%0b actual=%h expected=%h",
                     req, it.x, it.y, it.c, act, exp);
        end
    endtask

    // Apply one vector and queue its expected outputs.
    task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        item_t       it;
        logic [W:0]  tot;
        logic [W:0]  tot0;
        @(posedge clk);
        #1;
        tot  = {1'b0, x} + {1'b0, y} + (W+1)'(c);
        tot0 = {1'b0, x} + {1'b0, y};
        it.x = x; it.y = y; it.c = c;
        it.exp_sum = tot[W-1:0];
        it.exp_co  = tot[W];
        it.exp_g   = tot0[W];
        it.exp_p   = ((x ^ y) == {W{1'b1}});
        op_x = x; op_y = y; carry_in = c;
        sb_q.push_back(it);
    endtask

    // Monitor: pop and compare all outputs of both instances.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check("R1 sum", sum, it.exp_sum, it);
            check("R2 carry_out", W'(carry_out), W'(it.exp_co), it);
            check("R3 grp_gen", W'(grp_gen), W'(it.exp_g), it);
            check("R4 grp_prop", W'(grp_prop), W'(it.exp_p), it);
            check("R7 alt sum", sum_alt, it.exp_sum, it);
            check("R7 alt carry_out", W'(co_alt), W'(it.exp_co), it);
            check("R7 alt grp_gen", W'(g_alt), W'(it.exp_g), it);
            check("R7 alt grp_prop", W'(p_alt), W'(it.exp_p), it);
            if (it.exp_p) begin
                // R5: full propagate chain passes carry-in, no generate
                check("R5 passthrough co", W'(carry_out), W'(it.c), it);
                check("R5 passthrough sum", sum, it.c ? '0 : {W{1'b1}}, it);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > 200000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=200000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // Reset state: zero inputs give zero outputs (R1, R2, R3, R4)
        drive(16'h0000, 16'h0000, 1'b0);
        // R5: propagate chains with and without carry-in
        drive(16'hFFFF, 16'h0000, 1'b1);
        drive(16'hFFFF, 16'h0000, 1'b0);
        drive(16'hAAAA, 16'h5555, 1'b1);
        drive(16'h5555, 16'hAAAA, 1'b0);
        // R3: generate must ignore carry-in
        drive(16'hFFFF, 16'hFFFF, 1'b0);
        drive(16'hFFFF, 16'hFFFF, 1'b1);
        drive(16'h8000, 16'h8000, 1'b0);
        drive(16'h7FFF, 16'h8000, 1'b0);
        // R6: carries crossing slice boundaries 4, 8, 12
        drive(16'h000F, 16'h0001, 1'b0);
        drive(16'h00FF, 16'h0000, 1'b1);
        drive(16'h0FFF, 16'h0001, 1'b0);
        drive(16'h0FF0, 16'h0010, 1'b0);
        drive(16'hF0F0, 16'h0F0F, 1'b1);
        drive(16'h1234, 16'hEDCB, 1'b1);
        // R1, R2: random operands
        for (int n = 0; n < 400; n++) begin
            drive(W'($urandom), W'($urandom), 1'($urandom));
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule